// File: doc/BRIEF.md
# Serial-Loaded Synthesizer Divider Programming Registers

This block takes a three-wire serial stream (data, shift clock, active-low enable) and turns it into the divider settings of a frequency synthesizer. While the enable line is held low, each rising edge of the shift clock moves one bit into a shift stage, most significant bit first. When the enable line returns high, the word is committed. The number of bits received picks the destination: a 24-bit word sets the main divide value N and the swallow divide value A, a 16-bit word sets the reference divide value, and an 8-bit word sets the control byte. A word of any other length is dropped.

The reference divide value is double-buffered. A newly loaded value waits in a pending stage and reaches the active output only when the reference counter signals its terminal count, so the counter never sees a modulus change in the middle of a cycle. The three serial lines are treated as asynchronous and pass through a synchronizer into the system clock domain. The reset values give divide-by-125 on the reference path and N = 27, A = 22 on the main path.

Top module: `synth_prog_regs`

## Requirements
- R1: After reset, n_div = 27, a_div = 22, r_div = 125 and ctrl = 0.
- R2: A bit is captured only on a rising edge of ser_clk while ser_en_n is low; ser_clk edges while ser_en_n is high are not counted and do not shift data.
- R3: Bits enter most significant bit first. A 24-bit word sets n_div from word bits [23:12] and a_div from word bits [5:0]; word bits [11:6] are ignored.
- R4: A 16-bit word loads word bits [13:0] as the pending reference value; bits [15:14] are ignored. The value reaches r_div at the next ref_tc pulse.
- R5: An 8-bit word loads ctrl from word bits [7:0].
- R6: A word of any length other than 8, 16 or 24 bits, including zero bits and more than 24 bits, leaves n_div, a_div, ctrl, r_div and the pending reference value unchanged.
- R7: r_div changes only in the clock cycle that follows a cycle with ref_tc high, and only if a reference value is pending; a ref_tc pulse with nothing pending leaves r_div unchanged.
- R8: No register changes while ser_en_n stays low; the bit count restarts from zero for each word.
- R9: If a second 16-bit word arrives before ref_tc, it replaces the first, and only the latest value reaches r_div.
- R10: A committed word is visible on the outputs after the (SYNC_STAGES+1)th rising edge of clk that follows the rise of ser_en_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data, sampled on a rising edge of ser_clk |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_en_n | input | 1 | Active-low load enable; a rising edge commits the word |
| ref_tc | input | 1 | Terminal-count pulse from the reference counter, synchronous to clk |
| n_div | output | N_W (12) | Main divide value |
| a_div | output | A_W (6) | Swallow divide value |
| r_div | output | R_W (14) | Active reference divide value |
| ctrl | output | C_W (8) | Control byte |

## Verification
The hardest situation to reach from the ports is the timing of the double buffer. A reference word must sit pending across other traffic, possibly be overwritten by a second reference word, and then move to r_div only on the exact cycle after a ref_tc pulse. Directed sequences cover each ordering: load then pulse, load twice then pulse, and pulse with nothing pending. Random stimulus then mixes reference loads, other word lengths, stray shift clocks while disabled and unsolicited ref_tc pulses, and checks all outputs against a bench model after every step.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

   // Destination of a committed serial word.
   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_CTRL = 2'd1,
      DST_REF  = 2'd2,
      DST_DIV  = 2'd3
   } dest_e;

   // The destination follows from the word length alone.
   function automatic dest_e pick_dest(input int cnt, input int len_c,
                                       input int len_r, input int len_a);
      if (cnt == len_a)      return DST_DIV;
      else if (cnt == len_r) return DST_REF;
      else if (cnt == len_c) return DST_CTRL;
      else                   return DST_NONE;
   endfunction

endpackage

// File: rtl/synth_in_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module synth_in_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/synth_ser_shift.sv
// Shift stage and bit counter; detects shift-clock and enable edges.
module synth_ser_shift #(
   parameter int LEN_MAX = 24,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_clk,
   input  logic               s_data,
   input  logic               s_en,     // synchronized enable, high = idle
   output logic [LEN_MAX-1:0] shreg,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic               commit
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(LEN_MAX + 1);

   logic clk_q, en_q, clk_rise;

   assign clk_rise = s_clk & ~clk_q;
   assign commit   = s_en & ~en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q   <= 1'b0;
         en_q    <= 1'b1;
         shreg   <= '0;
         bit_cnt <= '0;
      end else begin
         clk_q <= s_clk;
         en_q  <= s_en;
         if (commit) begin
            bit_cnt <= '0;
         end else if (!s_en && clk_rise) begin
            shreg <= {shreg[LEN_MAX-2:0], s_data};
            if (bit_cnt != SAT) bit_cnt <= bit_cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/synth_word_dec.sv
// Turns a commit and a bit count into one load strobe.
module synth_word_dec
   import synth_prog_pkg::*;
#(
   parameter int LEN_A = 24,
   parameter int LEN_R = 16,
   parameter int LEN_C = 8,
   parameter int CNT_W = 5
) (
   input  logic             commit,
   input  logic [CNT_W-1:0] bit_cnt,
   output logic             ld_div,
   output logic             ld_ref,
   output logic             ld_ctrl
);
   dest_e dest;

   always_comb begin
      dest = DST_NONE;
      if (commit) dest = pick_dest(int'(bit_cnt), LEN_C, LEN_R, LEN_A);
   end

   assign ld_div  = (dest == DST_DIV);
   assign ld_ref  = (dest == DST_REF);
   assign ld_ctrl = (dest == DST_CTRL);
endmodule

// File: rtl/synth_div_regs.sv
// Main divider pair and control byte.
module synth_div_regs #(
   parameter int N_W = 12,
   parameter int A_W = 6,
   parameter int C_W = 8,
   parameter logic [N_W-1:0] N_RST = 12'd27,
   parameter logic [A_W-1:0] A_RST = 6'd22,
   parameter logic [C_W-1:0] C_RST = 8'd0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_div,
   input  logic           ld_ctrl,
   input  logic [N_W-1:0] n_word,
   input  logic [A_W-1:0] a_word,
   input  logic [C_W-1:0] c_word,
   output logic [N_W-1:0] n_div,
   output logic [A_W-1:0] a_div,
   output logic [C_W-1:0] ctrl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_div <= N_RST;
         a_div <= A_RST;
      end else if (ld_div) begin
         n_div <= n_word;
         a_div <= a_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl <= C_RST;
      else if (ld_ctrl) ctrl <= c_word;
   end
endmodule

// File: rtl/synth_ref_buf.sv
// Reference divide value: buffered until terminal count, or direct.
module synth_ref_buf #(
   parameter int R_W        = 14,
   parameter bit R_BUFFERED = 1'b1,
   parameter logic [R_W-1:0] R_RST = 14'd125
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_ref,
   input  logic [R_W-1:0] r_word,
   input  logic           ref_tc,
   output logic [R_W-1:0] r_div
);
   generate
      if (R_BUFFERED) begin : g_dbl
         logic [R_W-1:0] pend;
         logic           pend_v;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend   <= R_RST;
               pend_v <= 1'b0;
               r_div  <= R_RST;
            end else begin
               if (ref_tc && pend_v) r_div <= pend;
               if (ld_ref) begin
                  pend   <= r_word;
                  pend_v <= 1'b1;
               end else if (ref_tc) begin
                  pend_v <= 1'b0;
               end
            end
         end
      end else begin : g_direct
         logic tc_unused;
         assign tc_unused = ref_tc;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      r_div <= R_RST;
            else if (ld_ref) r_div <= r_word;
         end
      end
   endgenerate
endmodule

// File: rtl/synth_prog_regs.sv
// Top: three-wire serial loader for synthesizer divider registers.
module synth_prog_regs #(
   parameter int LEN_A       = 24,
   parameter int LEN_R       = 16,
   parameter int LEN_C       = 8,
   parameter int N_W         = 12,
   parameter int A_W         = 6,
   parameter int R_W         = 14,
   parameter int C_W         = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit R_BUFFERED  = 1'b1,
   parameter logic [N_W-1:0] N_RST = 12'd27,
   parameter logic [A_W-1:0] A_RST = 6'd22,
   parameter logic [R_W-1:0] R_RST = 14'd125,
   parameter logic [C_W-1:0] C_RST = 8'd0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_data,
   input  logic           ser_clk,
   input  logic           ser_en_n,
   input  logic           ref_tc,
   output logic [N_W-1:0] n_div,
   output logic [A_W-1:0] a_div,
   output logic [R_W-1:0] r_div,
   output logic [C_W-1:0] ctrl
);
   localparam int CNT_W = $clog2(LEN_A + 2);

   // Elaboration-time parameter checks.
   if (!(LEN_C < LEN_R && LEN_R < LEN_A))
      $error("word lengths must be distinct and ordered control < reference < divider");
   if (N_W + A_W > LEN_A) $error("N and A fields do not fit the divider word");
   if (R_W > LEN_R)       $error("reference field wider than its word");
   if (C_W > LEN_C)       $error("control field wider than its word");
   if (SYNC_STAGES < 2)   $error("synchronizer needs at least two stages");

   logic             s_clk, s_data, s_en;
   logic [LEN_A-1:0] shreg;
   logic [CNT_W-1:0] bit_cnt;
   logic             commit;
   logic             ld_div, ld_ref, ld_ctrl;

   synth_in_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_en_n, ser_clk, ser_data}),
      .q     ({s_en, s_clk, s_data})
   );

   synth_ser_shift #(
      .LEN_MAX (LEN_A),
      .CNT_W   (CNT_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_clk   (s_clk),
      .s_data  (s_data),
      .s_en    (s_en),
      .shreg   (shreg),
      .bit_cnt (bit_cnt),
      .commit  (commit)
   );

   synth_word_dec #(
      .LEN_A (LEN_A),
      .LEN_R (LEN_R),
      .LEN_C (LEN_C),
      .CNT_W (CNT_W)
   ) u_dec (
      .commit  (commit),
      .bit_cnt (bit_cnt),
      .ld_div  (ld_div),
      .ld_ref  (ld_ref),
      .ld_ctrl (ld_ctrl)
   );

   synth_div_regs #(
      .N_W   (N_W),
      .A_W   (A_W),
      .C_W   (C_W),
      .N_RST (N_RST),
      .A_RST (A_RST),
      .C_RST (C_RST)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_div  (ld_div),
      .ld_ctrl (ld_ctrl),
      .n_word  (shreg[LEN_A-1 -: N_W]),
      .a_word  (shreg[A_W-1:0]),
      .c_word  (shreg[C_W-1:0]),
      .n_div   (n_div),
      .a_div   (a_div),
      .ctrl    (ctrl)
   );

   synth_ref_buf #(
      .R_W        (R_W),
      .R_BUFFERED (R_BUFFERED),
      .R_RST      (R_RST)
   ) u_ref (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_ref (ld_ref),
      .r_word (shreg[R_W-1:0]),
      .ref_tc (ref_tc),
      .r_div  (r_div)
   );
endmodule

// File: rtl/synth_prog_regs_chk.sv
// Property checker, bound to the top module.
module synth_prog_regs_chk #(
   parameter int LEN_A      = 24,
   parameter int N_W        = 12,
   parameter int A_W        = 6,
   parameter int R_W        = 14,
   parameter int C_W        = 8,
   parameter int CNT_W      = 5,
   parameter bit R_BUFFERED = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           s_en,
   input logic [CNT_W-1:0] bit_cnt,
   input logic           ld_div,
   input logic           ld_ref,
   input logic           ld_ctrl,
   input logic           ref_tc,
   input logic [N_W-1:0] n_div,
   input logic [A_W-1:0] a_div,
   input logic [R_W-1:0] r_div,
   input logic [C_W-1:0] ctrl
);
   // R2: with the enable idle for two cycles the counter sits at zero.
   a_r2_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (s_en && $past(s_en)) |-> (bit_cnt == '0));

   // R6: the counter never runs past one beyond the longest word.
   a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bit_cnt) <= LEN_A + 1);

   // R3: the divider pair changes only after a divider-word load.
   a_r3_div_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (n_div != $past(n_div) || a_div != $past(a_div)) |-> $past(ld_div));

   // R5: the control byte changes only after a control-word load.
   a_r5_ctrl_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl != $past(ctrl)) |-> $past(ld_ctrl));

   // R7: the active reference value moves only after terminal count.
   a_r7_ref_only_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (r_div != $past(r_div)) |-> (R_BUFFERED ? $past(ref_tc) : $past(ld_ref)));

   // R8: a load happens only on the rise of the synchronized enable.
   a_r8_load_on_en_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_div || ld_ref || ld_ctrl) |-> (s_en && !$past(s_en)));
endmodule

bind synth_prog_regs synth_prog_regs_chk #(
   .LEN_A      (LEN_A),
   .N_W        (N_W),
   .A_W        (A_W),
   .R_W        (R_W),
   .C_W        (C_W),
   .CNT_W      (CNT_W),
   .R_BUFFERED (R_BUFFERED)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_en    (s_en),
   .bit_cnt (bit_cnt),
   .ld_div  (ld_div),
   .ld_ref  (ld_ref),
   .ld_ctrl (ld_ctrl),
   .ref_tc  (ref_tc),
   .n_div   (n_div),
   .a_div   (a_div),
   .r_div   (r_div),
   .ctrl    (ctrl)
);

// File: tb/synth_prog_regs_tb.sv
module synth_prog_regs_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  HOLD       = 3;
   localparam int  STAGES     = 2;
   localparam int  WDOG       = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_en_n = 1'b1;
   logic        ref_tc = 1'b0;
   logic [11:0] n_div;
   logic [5:0]  a_div;
   logic [13:0] r_div;
   logic [7:0]  ctrl;

   int vectors = 0;
   int miscompares = 0;

   // Bench model state.
   logic [11:0] exp_n = 12'd27;
   logic [5:0]  exp_a = 6'd22;
   logic [13:0] exp_r = 14'd125;
   logic [7:0]  exp_c = 8'd0;
   logic [13:0] pend_r = 14'd0;
   logic        pend_v = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   synth_prog_regs dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_data (ser_data),
      .ser_clk  (ser_clk),
      .ser_en_n (ser_en_n),
      .ref_tc   (ref_tc),
      .n_div    (n_div),
      .a_div    (a_div),
      .r_div    (r_div),
      .ctrl     (ctrl)
   );

   function automatic logic [11:0] field_n(input logic [31:0] v); return v[23:12]; endfunction
   function automatic logic [5:0]  field_a(input logic [31:0] v); return v[5:0];   endfunction
   function automatic logic [13:0] field_r(input logic [31:0] v); return v[13:0];  endfunction
   function automatic logic [7:0]  field_c(input logic [31:0] v); return v[7:0];   endfunction

   task automatic cmp(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      cmp(req, "n_div", 32'(n_div), 32'(exp_n));
      cmp(req, "a_div", 32'(a_div), 32'(exp_a));
      cmp(req, "r_div", 32'(r_div), 32'(exp_r));
      cmp(req, "ctrl",  32'(ctrl),  32'(exp_c));
   endtask

   task automatic wait_neg(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      ser_data = b;
      wait_neg(HOLD);
      ser_clk = 1'b1;
      wait_neg(HOLD);
      ser_clk = 1'b0;
      wait_neg(HOLD);
   endtask

   // Shift clock pulses while the enable is idle: must be ignored (R2).
   task automatic stray_clocks(input int k);
      for (int i = 0; i < k; i++) shift_bit(1'($urandom));
   endtask

   task automatic open_word();
      @(negedge clk);
      ser_en_n = 1'b0;
      wait_neg(HOLD);
   endtask

   // Raise the enable and stop exactly when the result must be visible (R10).
   task automatic close_word(input int len, input logic [31:0] v);
      @(negedge clk);
      ser_en_n = 1'b1;
      repeat (STAGES + 1) @(posedge clk);
      @(negedge clk);
      if (len == 24) begin
         exp_n = field_n(v);
         exp_a = field_a(v);
      end else if (len == 16) begin
         pend_r = field_r(v);
         pend_v = 1'b1;
      end else if (len == 8) begin
         exp_c = field_c(v);
      end
   endtask

   task automatic send_word(input int len, input logic [31:0] v);
      open_word();
      for (int i = len - 1; i >= 0; i--) shift_bit(v[i]);
      close_word(len, v);
   endtask

   task automatic pulse_tc();
      @(negedge clk);
      ref_tc = 1'b1;
      @(negedge clk);
      ref_tc = 1'b0;
      if (pend_v) begin
         exp_r  = pend_r;
         pend_v = 1'b0;
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired before the run ended");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'd7717));
      wait_neg(4);
      rst_n = 1'b1;
      wait_neg(2);
      check_all("R1 reset");

      // R2: stray shift clocks with enable idle, then a control word.
      stray_clocks(5);
      check_all("R2 stray clocks");
      send_word(8, 32'hA5);
      check_all("R2/R5 control word after stray clocks");

      // R3: divider word with reserved middle bits all set.
      send_word(24, 32'h3C9FC5);
      check_all("R3 divider word");
      send_word(24, {8'h0, 12'd27, 6'h00, 6'd22});
      check_all("R3 divider 27/22");

      // R4/R7: reference load waits for terminal count.
      send_word(16, 32'hC07D);
      check_all("R7 pending held before ref_tc");
      pulse_tc();
      check_all("R4 reference applied at ref_tc");
      pulse_tc();
      check_all("R7 ref_tc with nothing pending");

      // R9: second reference word before terminal count wins.
      send_word(16, 32'h1234);
      send_word(16, 32'h0FA0);
      check_all("R9 two loads pending");
      pulse_tc();
      check_all("R9 latest reference applied");

      // R6: wrong lengths are discarded, including one pending check.
      send_word(16, 32'h0333);
      send_word(25, 32'h1FFFFFF);
      send_word(7, 32'h55);
      send_word(0, 32'h0);
      send_word(23, 32'h7FFFFF);
      check_all("R6 wrong lengths discarded");
      pulse_tc();
      check_all("R6 pending survives discarded words");

      // R8: nothing applies while the enable stays low.
      open_word();
      for (int i = 7; i >= 0; i--) shift_bit(1'(8'h3C >> i));
      wait_neg(6);
      check_all("R8 no change before enable rises");
      close_word(8, 32'h3C);
      check_all("R8/R10 control word applied on enable rise");

      // Random mix.
      for (int it = 0; it < 60; it++) begin
         int          kind;
         int          len;
         logic [31:0] v;
         kind = int'($urandom_range(5, 0));
         v    = $urandom;
         case (kind)
            0: begin send_word(8, v);  check_all("R5 random control"); end
            1: begin send_word(16, v); check_all("R4 random reference load"); end
            2: begin send_word(24, v); check_all("R3 random divider"); end
            3: begin
               len = int'($urandom_range(30, 0));
               send_word(len, v);
               check_all("R6 random length");
            end
            4: begin pulse_tc(); check_all("R7 random ref_tc"); end
            default: begin
               stray_clocks(int'($urandom_range(4, 1)));
               send_word(8, v);
               check_all("R2 random stray clocks");
            end
         endcase
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule